// File: doc/BRIEF.md
# Branch, Call and Return Sequencer

This block carries out the control-flow instructions of an 8-bit processor that has a 16-bit address space. An external decoder hands it an instruction kind, a condition code and the current flags. The block then steps through the instruction one clock-enabled cycle at a time. Each step is either a byte access on a single memory port or an internal cycle. It fetches immediate operand bytes at the program counter, keeps return addresses on a stack that grows downward, and ends with new program counter and stack pointer values and a one-clock completion pulse.

The caller presents `pc_in` as the address of the first operand byte, together with `sp_in` and `hl_in`, in the same cycle as `start`. Memory is read combinationally: `mem_rdata` must reflect `mem_addr` within the step, and the block samples it on the enabled edge that ends that step. A write takes effect on an enabled edge while `mem_wr` is high. The kind encoding is 0 absolute jump, 1 relative jump, 2 call, 3 return, 4 return-from-interrupt, 5 restart, 6 jump to the HL pair, and 7 reserved. The condition codes are 0 always, 1 zero clear, 2 zero set, 3 carry clear and 4 carry set; codes 5 to 7 behave exactly like code 0.

Top module: `flow_seq`

## Requirements
- R1: Flags and condition code are captured with `start`. The condition is true for code 0 and codes 5-7, for code 1 when `flag_z`=0, for code 2 when `flag_z`=1, for code 3 when `flag_c`=0, and for code 4 when `flag_c`=1.
- R2: An absolute jump (kind 0) reads the low byte at PC and then the high byte at PC+1. When taken, it takes one further internal step (3 steps in all) and loads PC with high<<8 | low. When not taken, it ends after 2 steps with PC advanced by 2.
- R3: A relative jump (kind 1) reads one byte at PC. When taken, it loads PC with PC+1 plus that byte read as a signed value, in 2 steps. When not taken, it ends after 1 step with PC+1.
- R4: A call (kind 2) reads the target low byte and then the high byte, and tests the condition afterwards. When taken, it spends an internal step, writes the high byte of PC+2 at SP-1, then writes the low byte at SP-2, leaves SP-2 and loads PC with the target (5 steps). When not taken, it ends after 2 steps with PC+2.
- R5: An unconditional return (kind 3, code 0/5-7) reads the low byte at SP and the high byte at SP+1, sets SP+2, and ends with one stall step (3 steps). A conditional return first spends one internal step and only then tests its condition: 4 steps when taken, or 1 step with PC and SP unchanged when not taken.
- R6: Return-from-interrupt (kind 4) behaves as an unconditional return whatever its code, and raises `ie_req` for exactly the clock in which `done` is high.
- R7: A restart (kind 5) spends one internal step, writes the high byte of PC at SP-1 and the low byte at SP-2, leaves SP-2 and loads PC with `rst_vec`*8 (3 steps).
- R8: A jump to HL (kind 6) loads PC from `hl_in`, performs no memory access, and raises `done` on the clock right after the `start` edge.
- R9: The block advances exactly one step per clock with `cke` high. While `cke` is low, the address and both strobes hold.
- R10: `done` is high for exactly one clock per instruction, and `mem_rd` and `mem_wr` are never high together.
- R11: A synchronous active-high reset returns the block to idle, with both strobes low and `done` low, including in the middle of a sequence.
- R12: `start` is ignored while a sequence is in progress, and a `start` with kind 7 produces no access, no `done` and no change to PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Step enable; one step per enabled edge |
| start | input | 1 | Begin an instruction (sampled with cke high, when idle) |
| kind | input | 3 | Instruction kind code |
| cond | input | 3 | Condition code |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| rst_vec | input | 3 | Restart vector index |
| pc_in | input | 16 | PC, pointing at the first operand byte |
| sp_in | input | 16 | Stack pointer |
| hl_in | input | 16 | HL register pair value |
| mem_rdata | input | 8 | Read data for the current address |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| pc_out | output | 16 | Program counter value |
| sp_out | output | 16 | Stack pointer value |
| done | output | 1 | One-clock completion pulse |
| ie_req | output | 1 | Interrupt re-enable request |

## Verification
After the `start` edge, `done` is due after exactly as many enabled edges as the instruction has steps: 0 for the HL jump and up to 5 for a taken call. The final PC, SP and stacked bytes are valid in that same clock. The bench drives inputs and samples at the falling edge. It counts only the rising edges that had `cke` high, and compares that count with the step total worked out for the kind and condition. Some runs insert idle `cke` cycles, so a result that arrives early or late is caught. `done` is checked one clock later to confirm that it has fallen.

// File: rtl/flow_pkg.sv
package flow_pkg;

    typedef enum logic [2:0] {
        K_JP   = 3'd0,
        K_JR   = 3'd1,
        K_CALL = 3'd2,
        K_RET  = 3'd3,
        K_RETI = 3'd4,
        K_RST  = 3'd5,
        K_JPHL = 3'd6,
        K_NONE = 3'd7
    } kind_e;

    localparam logic [2:0] C_ALW = 3'd0;
    localparam logic [2:0] C_NZ  = 3'd1;
    localparam logic [2:0] C_Z   = 3'd2;
    localparam logic [2:0] C_NC  = 3'd3;
    localparam logic [2:0] C_CY  = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_OPLO  = 4'd1,
        S_OPHI  = 4'd2,
        S_INT   = 4'd3,
        S_PUSHH = 4'd4,
        S_PUSHL = 4'd5,
        S_POPL  = 4'd6,
        S_POPH  = 4'd7,
        S_STALL = 4'd8
    } step_e;

endpackage

// File: rtl/flow_cond.sv
module flow_cond
    import flow_pkg::*;
(
    input  logic [2:0] code,
    input  logic       fz,
    input  logic       fc,
    output logic       taken
);
    always_comb begin
        case (code)
            C_NZ:    taken = !fz;
            C_Z:     taken = fz;
            C_NC:    taken = !fc;
            C_CY:    taken = fc;
            default: taken = 1'b1;
        endcase
    end
endmodule

// File: rtl/flow_reladd.sv
module flow_reladd #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] off,
    output logic [AW-1:0] sum
);
    localparam int EXT_W = AW - DW;

    logic [AW-1:0] off_ext;

    assign off_ext = {{EXT_W{off[DW-1]}}, off};
    assign sum     = base + off_ext;
endmodule

// File: rtl/flow_seq.sv
module flow_seq
    import flow_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int VEC_W    = 3,
    parameter int VEC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic             start,
    input  logic [2:0]       kind,
    input  logic [2:0]       cond,
    input  logic             flag_z,
    input  logic             flag_c,
    input  logic [VEC_W-1:0] rst_vec,
    input  logic [AW-1:0]    pc_in,
    input  logic [AW-1:0]    sp_in,
    input  logic [AW-1:0]    hl_in,
    input  logic [DW-1:0]    mem_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [AW-1:0]    pc_out,
    output logic [AW-1:0]    sp_out,
    output logic             done,
    output logic             ie_req
);
    localparam logic [AW-1:0] STEP_V = AW'(VEC_STEP);
    localparam logic [AW-1:0] ONE_V  = AW'(1);
    localparam logic [AW-1:0] TWO_V  = AW'(2);

    typedef struct packed {
        step_e         st;
        kind_e         kind;
        logic [2:0]    cond;
        logic          fz;
        logic          fc;
        logic [AW-1:0] pc;
        logic [AW-1:0] sp;
        logic [AW-1:0] tgt;
        logic          done;
        logic          ie;
    } seq_t;

    seq_t q, d;

    logic          taken;
    logic [AW-1:0] pc_inc;
    logic [AW-1:0] rel_tgt;
    logic [AW-1:0] sp_dn;
    logic [AW-1:0] sp_up1;
    logic [2:0]    cond_eff;
    kind_e         kind_in;

    assign pc_inc   = q.pc + ONE_V;
    assign sp_dn    = q.sp - ONE_V;
    assign sp_up1   = q.sp + ONE_V;
    assign kind_in  = kind_e'(kind);
    assign cond_eff = (cond > C_CY) ? C_ALW : cond;

    flow_cond u_cond (
        .code  (q.cond),
        .fz    (q.fz),
        .fc    (q.fc),
        .taken (taken)
    );

    flow_reladd #(.AW(AW), .DW(DW)) u_rel (
        .base (pc_inc),
        .off  (mem_rdata),
        .sum  (rel_tgt)
    );

    // memory port is a pure function of the current step
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            S_OPLO, S_OPHI: begin
                mem_rd   = 1'b1;
                mem_addr = q.pc;
            end
            S_POPL: begin
                mem_rd   = 1'b1;
                mem_addr = q.sp;
            end
            S_POPH: begin
                mem_rd   = 1'b1;
                mem_addr = sp_up1;
            end
            S_PUSHH: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_dn;
                mem_wdata = q.pc[AW-1 -: DW];
            end
            S_PUSHL: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_dn;
                mem_wdata = q.pc[DW-1:0];
            end
            default: ;
        endcase
    end

    // next-state computation
    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.ie   = 1'b0;
        if (cke) begin
            case (q.st)
                S_IDLE: begin
                    if (start && kind_in != K_NONE) begin
                        d.kind = kind_in;
                        d.cond = cond_eff;
                        d.fz   = flag_z;
                        d.fc   = flag_c;
                        d.pc   = pc_in;
                        d.sp   = sp_in;
                        d.tgt  = '0;
                        case (kind_in)
                            K_JP, K_JR, K_CALL: d.st = S_OPLO;
                            K_RET:  d.st = (cond_eff == C_ALW) ? S_POPL : S_INT;
                            K_RETI: d.st = S_POPL;
                            K_RST: begin
                                d.st  = S_INT;
                                d.tgt = AW'(rst_vec) * STEP_V;
                            end
                            default: begin
                                d.pc   = hl_in;
                                d.done = 1'b1;
                            end
                        endcase
                    end
                end
                S_OPLO: begin
                    d.tgt[DW-1:0] = mem_rdata;
                    d.pc          = pc_inc;
                    if (q.kind == K_JR) begin
                        if (taken) begin
                            d.pc = rel_tgt;
                            d.st = S_STALL;
                        end else begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.st = S_OPHI;
                    end
                end
                S_OPHI: begin
                    d.tgt[AW-1 -: DW] = mem_rdata;
                    d.pc              = pc_inc;
                    if (!taken) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                    end else if (q.kind == K_JP) begin
                        d.pc = {mem_rdata, q.tgt[DW-1:0]};
                        d.st = S_STALL;
                    end else begin
                        d.st = S_INT;
                    end
                end
                S_INT: begin
                    if (q.kind == K_RET) begin
                        if (taken) begin
                            d.st = S_POPL;
                        end else begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.st = S_PUSHH;
                    end
                end
                S_PUSHH: begin
                    d.sp = sp_dn;
                    d.st = S_PUSHL;
                end
                S_PUSHL: begin
                    d.sp   = sp_dn;
                    d.pc   = q.tgt;
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end
                S_POPL: begin
                    d.tgt[DW-1:0] = mem_rdata;
                    d.st          = S_POPH;
                end
                S_POPH: begin
                    d.pc = {mem_rdata, q.tgt[DW-1:0]};
                    d.sp = q.sp + TWO_V;
                    d.st = S_STALL;
                end
                S_STALL: begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                    d.ie   = (q.kind == K_RETI);
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pc_out = q.pc;
    assign sp_out = q.sp;
    assign done   = q.done;
    assign ie_req = q.ie;

endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cke,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          ie_req
);
    logic armed_q;
    logic rst_q;

    always_ff @(posedge clk) begin
        armed_q <= !rst;
        rst_q   <= rst;
    end

    // R10: the port never reads and writes at once
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R10: completion lasts one clock
    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: a disabled clock holds the access
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !cke |=> ($stable(mem_addr) && $stable(mem_rd) && $stable(mem_wr)));

    // R6: the enable request comes only with completion
    assert_ie_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        ie_req |-> done);

    // R4: back-to-back stack writes walk downward
    assert_push_desc_R4: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(cke && mem_wr) && mem_wr) |-> (mem_addr == $past(mem_addr) - AW'(1)));

    // R11: the clock after reset is idle
    assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!mem_rd && !mem_wr && !done));

endmodule

bind flow_seq flow_seq_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .done     (done),
    .ie_req   (ie_req)
);

// File: tb/flow_seq_bench.sv
`timescale 1ns/1ps
module flow_seq_bench;
    logic        clk = 1'b0;
    logic        rst, cke, start, flag_z, flag_c;
    logic [2:0]  kind, cond, rst_vec;
    logic [15:0] pc_in, sp_in, hl_in;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata;
    logic        mem_rd, mem_wr, done, ie_req;

    logic [7:0]  mem [256];
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    flow_seq u_flow_seq (
        .clk(clk), .rst(rst), .cke(cke), .start(start), .kind(kind), .cond(cond),
        .flag_z(flag_z), .flag_c(flag_c), .rst_vec(rst_vec), .pc_in(pc_in),
        .sp_in(sp_in), .hl_in(hl_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_out(pc_out),
        .sp_out(sp_out), .done(done), .ie_req(ie_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit cond_true(input logic [2:0] c, input logic z, input logic cy);
        case (c)
            3'd1: return !z;
            3'd2: return z;
            3'd3: return !cy;
            3'd4: return cy;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] k);
        case (k)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic run_case(input int idx, input logic [2:0] k, input logic [2:0] c,
                            input logic z, input logic cy, input bit gaps, input bit interfere);
        logic [15:0] pcv, spv, hlv, e_pc, e_sp, ret;
        logic [7:0]  b0, b1, b2, b3;
        logic [15:0] w_addr [4];
        logic [7:0]  w_data [4];
        logic [15:0] e_waddr [2];
        logic [7:0]  e_wdata [2];
        logic [2:0]  vec;
        int          e_steps, e_wn, steps, wn, cyc;
        bit          t, unc, e_ie;
        string       rq;
        pcv = {8'h12 + 8'(idx), 8'h30 + 8'(idx % 8)};
        spv = 16'h80F0;
        hlv = 16'hA000 ^ 16'(idx * 97);
        vec = 3'(idx % 8);
        b0 = 8'(idx * 37 + 5);
        b1 = 8'(idx * 11 + 64);
        b2 = 8'(idx * 53 + 9);
        b3 = 8'(idx * 7 + 32);
        mem[pcv[7:0]] = b0;
        mem[pcv[7:0] + 8'd1] = b1;
        mem[8'hF0] = b2;
        mem[8'hF1] = b3;
        mem[8'hEF] = 8'h00;
        mem[8'hEE] = 8'h00;
        // expected results from the requirements
        t = cond_true(c, z, cy);
        unc = (c == 3'd0) || (c > 3'd4);
        e_pc = pcv; e_sp = spv; e_steps = 0; e_wn = 0; e_ie = 0;
        e_waddr[0] = 0; e_waddr[1] = 0; e_wdata[0] = 0; e_wdata[1] = 0;
        case (k)
            3'd0: if (t) begin e_steps = 3; e_pc = {b1, b0}; end
                  else begin e_steps = 2; e_pc = pcv + 16'd2; end
            3'd1: if (t) begin e_steps = 2; e_pc = pcv + 16'd1 + {{8{b0[7]}}, b0}; end
                  else begin e_steps = 1; e_pc = pcv + 16'd1; end
            3'd2: if (t) begin
                      ret = pcv + 16'd2;
                      e_steps = 5; e_pc = {b1, b0}; e_sp = spv - 16'd2; e_wn = 2;
                      e_waddr[0] = spv - 16'd1; e_wdata[0] = ret[15:8];
                      e_waddr[1] = spv - 16'd2; e_wdata[1] = ret[7:0];
                  end else begin e_steps = 2; e_pc = pcv + 16'd2; end
            3'd3: if (unc) begin e_steps = 3; e_pc = {b3, b2}; e_sp = spv + 16'd2; end
                  else if (t) begin e_steps = 4; e_pc = {b3, b2}; e_sp = spv + 16'd2; end
                  else e_steps = 1;
            3'd4: begin e_steps = 3; e_pc = {b3, b2}; e_sp = spv + 16'd2; e_ie = 1; end
            3'd5: begin
                      e_steps = 3; e_pc = 16'(vec) * 16'd8; e_sp = spv - 16'd2; e_wn = 2;
                      e_waddr[0] = spv - 16'd1; e_wdata[0] = pcv[15:8];
                      e_waddr[1] = spv - 16'd2; e_wdata[1] = pcv[7:0];
                  end
            default: e_pc = hlv;
        endcase
        rq = req_of(k);
        // launch
        kind = k; cond = c; flag_z = z; flag_c = cy; rst_vec = vec;
        pc_in = pcv; sp_in = spv; hl_in = hlv; start = 1'b1; cke = 1'b1;
        @(negedge clk);
        start = 1'b0;
        steps = 0; wn = 0; cyc = 0;
        while (!done && cyc < 40) begin
            cke = !(gaps && (cyc % 3 == 2));
            if (interfere && cyc == 1) begin
                start = 1'b1; kind = 3'd6; hl_in = 16'hDEAD;
                flag_z = !z; flag_c = !cy;
            end else begin
                start = 1'b0;
            end
            #1;
            if (cke) steps++;
            if (cke && mem_wr && wn < 4) begin
                w_addr[wn] = mem_addr; w_data[wn] = mem_wdata; wn++;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; cke = 1'b1;
        chk(done == 1'b1, rq, "done seen", 32'(done), 1);
        chk(steps == e_steps, gaps ? "R9" : ((k == 3'd0) ? "R1" : rq), "step count",
            32'(steps), 32'(e_steps));
        chk(pc_out == e_pc, interfere ? "R12" : rq, "pc", 32'(pc_out), 32'(e_pc));
        chk(sp_out == e_sp, rq, "sp", 32'(sp_out), 32'(e_sp));
        chk(ie_req == e_ie, "R6", "ie_req", 32'(ie_req), 32'(e_ie));
        chk(wn == e_wn, rq, "write count", 32'(wn), 32'(e_wn));
        for (int i = 0; i < 2; i++) begin
            if (i < e_wn && i < wn) begin
                chk(w_addr[i] == e_waddr[i], rq, "write addr", 32'(w_addr[i]), 32'(e_waddr[i]));
                chk(w_data[i] == e_wdata[i], rq, "write data", 32'(w_data[i]), 32'(e_wdata[i]));
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", 32'(done), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] pc_keep;
        int idx;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        rst = 1'b1; cke = 1'b1; start = 1'b0; kind = 3'd0; cond = 3'd0;
        flag_z = 1'b0; flag_c = 1'b0; rst_vec = 3'd0;
        pc_in = 16'h0; sp_in = 16'h0; hl_in = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 idle after reset
        chk(!mem_rd && !mem_wr && !done, "R11", "reset idle",
            {29'd0, mem_rd, mem_wr, done}, 0);

        idx = 0;
        for (int k = 0; k < 7; k++) begin
            for (int c = 0; c < 8; c++) begin
                for (int f = 0; f < 4; f++) begin
                    run_case(idx, 3'(k), 3'(c), f[0], f[1], idx % 2 == 1, idx % 5 == 0);
                    idx++;
                end
            end
        end

        // R12: reserved kind does nothing
        pc_keep = pc_out;
        kind = 3'd7; pc_in = 16'h5555; start = 1'b1; cke = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(!done && !mem_rd && !mem_wr, "R12", "reserved kind activity",
                {29'd0, done, mem_rd, mem_wr}, 0);
            @(negedge clk);
        end
        chk(pc_out == pc_keep, "R12", "reserved kind pc", 32'(pc_out), 32'(pc_keep));

        // R11: reset in the middle of a call
        kind = 3'd2; cond = 3'd0; pc_in = 16'h1230; sp_in = 16'h80F0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!mem_rd && !mem_wr && !done, "R11", "mid-sequence reset",
            {29'd0, mem_rd, mem_wr, done}, 0);
        @(negedge clk);
        chk(!mem_rd && !mem_wr && !done, "R11", "stays idle",
            {29'd0, mem_rd, mem_wr, done}, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule